// File: doc/BRIEF.md
# Trigger-Windowed Readout Capture Buffer

This block sits on a 40 MHz crossing-synchronous trigger path. It takes one input word per bunch crossing and keeps the most recent words in a short history register. On each level-1 accept it records five consecutive crossings as one event in a readout FIFO: the two crossings before the accepted one, the accepted crossing itself, and the two after it. Each event starts with a header word. The header carries the crossing number of the accepted crossing and two status bits.

A free-running crossing counter is cleared by the orbit-start strobe and wraps at the orbit length. It never stops, including when the FIFO is saturated. If the FIFO cannot hold a whole event, the payload is dropped. A header-only record with a drop flag then tells the reader that no fresh data was stored for that accept. An accept that arrives while a window is still being collected is queued. An accept that finds the queue full is refused and raises a sticky overrun bit that appears in every later header.

The reader sees the head of the FIFO on `rd_data` and `rd_hdr`, qualified by `rd_valid`. Raising `rd_pop` moves to the next word.

Top module: `trig_window_capture`

## Requirements
- R1: While `rst_n` is low, and until the core logic starts on the third rising edge after `rst_n` rises, `rd_empty` is 1, and both `rd_full` and `rd_valid` are 0.
- R2: The crossing counter is 0 after reset. It advances by one on every clock edge and returns to 0 after `BX_MAX-1` (3563). It keeps counting whatever the FIFO occupancy is.
- R3: When `bc0` is high at an edge, the counter is 0 after that edge. An accept sampled on the same edge still carries the counter value from before the edge.
- R4: Each stored event is a header followed by five payload words. The payload holds the inputs sampled at edges t-2, t-1, t, t+1 and t+2, oldest first, where t is the edge that sampled `l1a`. Inputs from before the core started count as 0.
- R5: The event enters the FIFO on edge t+2. For an empty FIFO, `rd_empty` stays 1 after edges t and t+1 and falls after edge t+2.
- R6: Header words have `rd_hdr`=1, and payload words have `rd_hdr`=0. Header bits [11:0] hold the accepted crossing number, bit 12 is the drop flag, bit 13 is the overrun flag, and bits [15:14] are 0.
- R7: Up to 2 accepts may be outstanding. An accept sampled while 2 entries are held, counted before the edge, is refused and sets the sticky overrun flag. Every later header then has bit 13 set. Headers written before the refusal do not.
- R8: At commit, the free space is taken from the FIFO level before the edge. With 6 or more free words the full event is written. With 1 to 5 free words only a header is written, with bit 12 set and bits [11:0] equal to the counter value at the commit edge. With no free word nothing is written.
- R9: `rd_full` is 1 exactly when the FIFO holds 16 words, `rd_empty` is 1 exactly when it holds none, and `rd_valid` is the inverse of `rd_empty`.
- R10: `rd_pop` with `rd_valid` high removes the head word at the edge. `rd_pop` on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | 16 | Trigger word for the current crossing |
| l1a | input | 1 | Level-1 accept for the current crossing |
| bc0 | input | 1 | Orbit start, clears the crossing counter |
| rd_pop | input | 1 | Consume the head word |
| rd_data | output | 16 | Head word of the readout FIFO |
| rd_hdr | output | 1 | Head word is an event header |
| rd_valid | output | 1 | Head word is present |
| rd_empty | output | 1 | FIFO holds no word |
| rd_full | output | 1 | FIFO holds 16 words |

## Verification
The capture function is driven with a rising ramp, walking ones and a pseudo-random sequence. The ramp shows whether the window is shifted by a crossing or reversed. Walking ones expose swapped or stuck bit lanes. The random data catches aliasing between neighbouring samples. Accept patterns cover isolated accepts, accepts on consecutive clocks (which queue and then overrun), accepts coinciding with or just after the orbit strobe, and a steady stream without reads that pushes the FIFO into header-only and dropped records. A long run with regular accepts carries the header crossing numbers across the orbit wrap while reads run at the same time as commits.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // What the commit stage writes into the readout FIFO on a given edge.
  typedef enum logic [1:0] {
    WR_NONE     = 2'd0,
    WR_HDR_ONLY = 2'd1,
    WR_EVENT    = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/tw_bx_counter.sv
module tw_bx_counter #(
  parameter int BX_MAX = 3564,
  parameter int BX_W   = $clog2(BX_MAX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bc0,
  output logic [BX_W-1:0] bx
);

  localparam logic [BX_W-1:0] LAST = BX_W'(BX_MAX - 1);

  logic [BX_W-1:0] bx_q, bx_d;
  logic            cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    bx_d = bx_q;
    if (cnt_en) begin
      if (bc0 || bx_q == LAST) bx_d = '0;
      else                     bx_d = bx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bx_q <= '0;
    else        bx_q <= bx_d;
  end

  assign bx = bx_q;

endmodule

// File: rtl/tw_l1a_queue.sv
module tw_l1a_queue #(
  parameter int QDEPTH = 2,
  parameter int BX_W   = 12,
  parameter int POST   = 2,
  parameter int LVL_W  = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l1a,
  input  logic [BX_W-1:0]  bx_in,
  output logic             done,
  output logic [BX_W-1:0]  done_bx,
  output logic             overrun,
  output logic [LVL_W-1:0] level
);

  localparam int AGE_W = $clog2(POST + 1);

  // Entries are kept in arrival order, oldest in slot 0. Only slot 0
  // can reach the final age, because ages of live entries are distinct.
  logic [BX_W-1:0]  bx_q  [QDEPTH];
  logic [AGE_W-1:0] age_q [QDEPTH];
  logic [BX_W-1:0]  bx_d  [QDEPTH];
  logic [AGE_W-1:0] age_d [QDEPTH];
  logic [BX_W-1:0]  bx_sh [QDEPTH+1];
  logic [AGE_W-1:0] age_sh[QDEPTH+1];
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             ovr_q, ovr_d;
  logic             pop_c, acc_c;
  int               slot;

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      bx_sh[i]  = bx_q[i];
      age_sh[i] = age_q[i];
    end
    bx_sh[QDEPTH]  = '0;
    age_sh[QDEPTH] = '0;

    pop_c = (lvl_q != '0) && (age_q[0] == AGE_W'(POST - 1));
    acc_c = l1a && (lvl_q < LVL_W'(QDEPTH));

    for (int i = 0; i < QDEPTH; i++) begin
      if (pop_c) begin
        bx_d[i]  = bx_sh[i+1];
        age_d[i] = age_sh[i+1] + 1'b1;
      end else begin
        bx_d[i]  = bx_sh[i];
        age_d[i] = age_sh[i] + 1'b1;
      end
    end

    slot = int'(lvl_q) - (pop_c ? 1 : 0);
    if (acc_c) begin
      bx_d[slot]  = bx_in;
      age_d[slot] = '0;
    end

    lvl_d = lvl_q - LVL_W'(pop_c) + LVL_W'(acc_c);
    ovr_d = ovr_q | (l1a & ~acc_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEPTH; i++) begin
        bx_q[i]  <= '0;
        age_q[i] <= '0;
      end
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        bx_q[i]  <= bx_d[i];
        age_q[i] <= age_d[i];
      end
      lvl_q <= lvl_d;
      ovr_q <= ovr_d;
    end
  end

  assign done    = pop_c;
  assign done_bx = bx_q[0];
  assign overrun = ovr_q;
  assign level   = lvl_q;

endmodule

// File: rtl/tw_event_fifo.sv
module tw_event_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  parameter int NW    = 6,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(NW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        wr_num,
  input  logic [NW-1:0][W-1:0] wr_words,
  input  logic                 pop,
  output logic [W-1:0]         rd_word,
  output logic [AW:0]          level,
  output logic                 full,
  output logic                 empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]   lvl_q, lvl_d;
  logic          pop_ok;

  assign pop_ok = pop && (lvl_q != '0);

  always_comb begin
    wptr_d = wptr_q + AW'(wr_num);
    rptr_d = rptr_q + AW'(pop_ok);
    lvl_d  = lvl_q + (AW+1)'(wr_num) - (AW+1)'(pop_ok);
  end

  // Storage is not reset; the level guards every read.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (i < int'(wr_num)) mem[wptr_q + AW'(i)] <= wr_words[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  assign rd_word = mem[rptr_q];
  assign level   = lvl_q;
  assign full    = (lvl_q == (AW+1)'(DEPTH));
  assign empty   = (lvl_q == '0);

endmodule

// File: rtl/trig_window_capture.sv
module trig_window_capture
  import tw_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int WIN        = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int BX_MAX     = 3564,
  parameter int QDEPTH     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              l1a,
  input  logic              bc0,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hdr,
  output logic              rd_valid,
  output logic              rd_empty,
  output logic              rd_full
);

  localparam int POST  = WIN / 2;
  localparam int HIST  = WIN - 1;
  localparam int NW    = WIN + 1;
  localparam int BX_W  = $clog2(BX_MAX);
  localparam int FW    = DATA_W + 1;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int CW    = $clog2(NW + 1);
  localparam int LVL_W = $clog2(QDEPTH + 1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  // Crossing counter.
  logic [BX_W-1:0] bx_now;
  tw_bx_counter #(.BX_MAX(BX_MAX), .BX_W(BX_W)) u_bx (
    .clk   (clk),
    .rst_n (rst_core_n),
    .bc0   (bc0),
    .bx    (bx_now)
  );

  // Pending accepts waiting for their trailing crossings.
  logic             done, ovr_flag;
  logic [BX_W-1:0]  done_bx;
  logic [LVL_W-1:0] q_lvl;
  tw_l1a_queue #(.QDEPTH(QDEPTH), .BX_W(BX_W), .POST(POST), .LVL_W(LVL_W)) u_q (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .l1a     (l1a),
    .bx_in   (bx_now),
    .done    (done),
    .done_bx (done_bx),
    .overrun (ovr_flag),
    .level   (q_lvl)
  );

  // History of past crossings, index 0 is the most recent.
  logic [DATA_W-1:0] hist_q [HIST];
  logic              hist_en;
  assign hist_en = 1'b1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
    end else if (hist_en) begin
      hist_q[0] <= in_data;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // Commit decision and event assembly.
  logic [AW:0]          fifo_lvl, fifo_free;
  wr_kind_e             kind;
  logic [DATA_W-1:0]    hdr;
  logic [CW-1:0]        wr_num;
  logic [NW-1:0][FW-1:0] words;
  logic [FW-1:0]        rd_word;

  assign fifo_free = (AW+1)'(FIFO_DEPTH) - fifo_lvl;

  always_comb begin
    kind = WR_NONE;
    if (done) begin
      if (int'(fifo_free) >= NW)   kind = WR_EVENT;
      else if (fifo_free != '0)    kind = WR_HDR_ONLY;
    end
  end

  always_comb begin
    hdr = '0;
    hdr[BX_W-1:0] = (kind == WR_EVENT) ? done_bx : bx_now;
    hdr[BX_W]     = (kind == WR_HDR_ONLY);
    hdr[BX_W+1]   = ovr_flag;
  end

  generate
    for (genvar k = 1; k <= HIST; k++) begin : g_payload
      assign words[k] = {1'b0, hist_q[HIST-k]};
    end
  endgenerate
  assign words[0]    = {1'b1, hdr};
  assign words[NW-1] = {1'b0, in_data};

  always_comb begin
    case (kind)
      WR_EVENT:    wr_num = CW'(NW);
      WR_HDR_ONLY: wr_num = CW'(1);
      default:     wr_num = '0;
    endcase
  end

  logic fifo_full, fifo_empty;
  tw_event_fifo #(.W(FW), .DEPTH(FIFO_DEPTH), .NW(NW), .AW(AW), .CW(CW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_num   (wr_num),
    .wr_words (words),
    .pop      (rd_pop),
    .rd_word  (rd_word),
    .level    (fifo_lvl),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  assign rd_data  = rd_word[DATA_W-1:0];
  assign rd_hdr   = rd_word[DATA_W] & ~fifo_empty;
  assign rd_valid = ~fifo_empty;
  assign rd_empty = fifo_empty;
  assign rd_full  = fifo_full;

endmodule

// File: rtl/tw_capture_checker.sv
module tw_capture_checker #(
  parameter int BX_W   = 12,
  parameter int BX_MAX = 3564,
  parameter int QDEPTH = 2,
  parameter int LVL_W  = 2,
  parameter int CW     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             l1a,
  input logic             bc0,
  input logic             rd_pop,
  input logic             rd_empty,
  input logic             rd_full,
  input logic [BX_W-1:0]  bx,
  input logic [LVL_W-1:0] q_lvl,
  input logic             ovr,
  input logic [CW-1:0]    wr_num
);

  assert_bx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bx < BX_W'(BX_MAX));

  assert_bx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc0 && bx != BX_W'(BX_MAX - 1)) |=> bx == BX_W'($past(bx) + 1'b1));

  assert_bc0_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bc0 |=> bx == '0);

  assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_lvl <= LVL_W'(QDEPTH));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

  assert_refused_sets_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && q_lvl == LVL_W'(QDEPTH)) |=> ovr);

  assert_empty_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_empty) |-> $past(wr_num) != '0);

  assert_full_empty_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_full && rd_empty));

  assert_pop_on_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_empty && rd_pop && wr_num == '0) |=> rd_empty);

endmodule

bind trig_window_capture tw_capture_checker #(
  .BX_W(BX_W), .BX_MAX(BX_MAX), .QDEPTH(QDEPTH), .LVL_W(LVL_W), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .l1a      (l1a),
  .bc0      (bc0),
  .rd_pop   (rd_pop),
  .rd_empty (rd_empty),
  .rd_full  (rd_full),
  .bx       (bx_now),
  .q_lvl    (q_lvl),
  .ovr      (ovr_flag),
  .wr_num   (wr_num)
);

// File: tb/trig_window_capture_test.sv
module trig_window_capture_test;

  localparam int DEPTH = 16;
  localparam int BXMAX = 3564;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] in_data;
  logic        l1a, bc0, rd_pop;
  logic [15:0] rd_data;
  logic        rd_hdr, rd_valid, rd_empty, rd_full;

  always #4 clk = ~clk;

  trig_window_capture uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .l1a(l1a), .bc0(bc0),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_hdr(rd_hdr), .rd_valid(rd_valid),
    .rd_empty(rd_empty), .rd_full(rd_full)
  );

  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // Behavioural reference model.
  logic [16:0] mf[$];
  int          hist[$];
  int          pend_bx[$];
  int          pend_age[$];
  int          m_bx;
  bit          m_ovr;
  int          rel;

  function automatic logic [16:0] mk_hdr(int bx, bit drop, bit ovr);
    logic [15:0] h;
    h = 16'(bx) | (16'(drop) << 12) | (16'(ovr) << 13);
    return {1'b1, h};
  endfunction

  task automatic model_reset();
    mf.delete(); hist.delete(); pend_bx.delete(); pend_age.delete();
    for (int i = 0; i < 4; i++) hist.push_back(0);
    m_bx = 0; m_ovr = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      rel = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      int  pre, room, npend, bx_pre;
      bit  ovr_pre, commit;
      pre = mf.size(); ovr_pre = m_ovr; bx_pre = m_bx; npend = pend_bx.size();
      commit = (npend > 0) && (pend_age[0] == 1);
      if (rd_pop && pre > 0) void'(mf.pop_front());
      if (commit) begin
        room = DEPTH - pre;
        if (room >= 6) begin
          mf.push_back(mk_hdr(pend_bx[0], 0, ovr_pre));
          mf.push_back({1'b0, 16'(hist[3])});
          mf.push_back({1'b0, 16'(hist[2])});
          mf.push_back({1'b0, 16'(hist[1])});
          mf.push_back({1'b0, 16'(hist[0])});
          mf.push_back({1'b0, in_data});
        end else if (room >= 1) begin
          mf.push_back(mk_hdr(bx_pre, 1, ovr_pre));
        end
        void'(pend_bx.pop_front());
        void'(pend_age.pop_front());
      end
      foreach (pend_age[i]) pend_age[i]++;
      if (l1a) begin
        if (npend < 2) begin
          pend_bx.push_back(bx_pre);
          pend_age.push_back(0);
        end else m_ovr = 1;
      end
      hist.push_front(int'(in_data));
      void'(hist.pop_back());
      m_bx = bc0 ? 0 : ((bx_pre == BXMAX - 1) ? 0 : bx_pre + 1);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit e_empty, e_full;
    e_empty = (mf.size() == 0);
    e_full  = (mf.size() == DEPTH);
    // R9: flags follow the occupancy
    check(rd_empty == e_empty, "R9", "rd_empty", int'(rd_empty), int'(e_empty));
    check(rd_full == e_full, "R9", "rd_full", int'(rd_full), int'(e_full));
    check(rd_valid == !e_empty, "R9", "rd_valid", int'(rd_valid), int'(!e_empty));
    if (!e_empty)
      check({rd_hdr, rd_data} == mf[0], cur_req, "head word",
            int'({rd_hdr, rd_data}), int'(mf[0]));
  endtask

  task automatic tick(bit a, bit b, bit p, logic [15:0] d);
    @(negedge clk);
    if (rst_n) compare();
    l1a = a; bc0 = b; rd_pop = p; in_data = d;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; l1a = 0; bc0 = 0; rd_pop = 0; in_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_empty == 1'b1, "R1", "rd_empty in reset", int'(rd_empty), 1);
    check(rd_full == 1'b0, "R1", "rd_full in reset", int'(rd_full), 0);
    check(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_empty == 1'b1, "R1", "rd_empty during release", int'(rd_empty), 1);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, '0);

    // R4 R5 R6: single accept on a ramp
    cur_req = "R4";
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 16'(100 + i));
    tick(1, 0, 0, 16'd106);
    tick(0, 0, 0, 16'd107);
    check(rd_empty == 1'b1, "R5", "empty after edge t", int'(rd_empty), 1);
    tick(0, 0, 0, 16'd108);
    check(rd_empty == 1'b1, "R5", "empty after edge t+1", int'(rd_empty), 1);
    tick(0, 0, 0, 16'd109);
    check(rd_empty == 1'b0, "R5", "empty after edge t+2", int'(rd_empty), 0);
    cur_req = "R6";
    for (int i = 0; i < 8; i++) tick(0, 0, 1, 16'(110 + i));

    // R4: walking ones with reads running
    cur_req = "R4";
    for (int i = 0; i < 64; i++) tick((i % 7) == 3, 0, 1, 16'(1) << (i % 16));

    // R3: orbit strobe with an accept on and after it
    cur_req = "R3";
    tick(0, 0, 1, 16'h1111);
    tick(1, 1, 1, 16'h2222);
    tick(1, 0, 1, 16'h3333);
    for (int i = 0; i < 16; i++) tick(0, 0, 1, 16'(16'h4000 + i));

    // R7: three accepts on consecutive clocks, then one more later
    cur_req = "R7";
    tick(1, 0, 1, 16'h5001);
    tick(1, 0, 1, 16'h5002);
    tick(1, 0, 1, 16'h5003);
    for (int i = 0; i < 14; i++) tick(0, 0, 1, 16'(16'h5100 + i));
    tick(1, 0, 1, 16'h5200);
    for (int i = 0; i < 12; i++) tick(0, 0, 1, 16'(16'h5300 + i));

    // R8: accepts without reads until the FIFO saturates
    cur_req = "R8";
    for (int i = 0; i < 30; i++) begin
      lfsr = nxt(lfsr);
      tick((i % 3) == 0, 0, 0, lfsr);
    end
    check(rd_full == 1'b1, "R9", "full after saturation", int'(rd_full), 1);

    // R10: drain past empty, pops on empty ignored
    cur_req = "R10";
    for (int i = 0; i < 24; i++) tick(0, 0, 1, 16'(i));
    check(rd_empty == 1'b1, "R10", "empty after drain", int'(rd_empty), 1);
    tick(1, 0, 1, 16'h7777);
    for (int i = 0; i < 3; i++) tick(0, 0, 1, 16'h7778);

    // R2: long run across the orbit wrap
    cur_req = "R2";
    for (int i = 0; i < 3800; i++) begin
      lfsr = nxt(lfsr);
      tick((i % 7) == 0, 0, (i % 3) != 2, lfsr);
    end
    for (int i = 0; i < 30; i++) tick(0, 0, 1, '0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule